// File: doc/BRIEF.md
# Manual Reference Selector and Lock Qualifier

This block decides which of three clock references feeds a digital PLL and reports whether that loop may be called locked. A two-bit select code from the board chooses the reference. The code passes through a synchronizer before the block acts on it. A separate two-bit mode code disables manual selection when it carries the automatic-mode value, and the select code then has no effect.

Lock is derived from an in-window flag that an upstream phase comparator supplies every clock cycle. A slower qualify tick paces the lock timer. A reference change never touches the lock state directly, so a switch to a close reference keeps lock high. If the switch pushes the phase out of the window, lock drops at once. It can come back only after a full lock-time of uninterrupted in-window ticks.

Top module: `ref_lock_ctl`

## Requirements
- R1: After reset the active reference index is 0, the switch pulse is low and lock is low.
- R2: The select code maps 00 to index 0, 01 to index 1, and both 10 and 11 to index 2. The code passes through a two-stage synchronizer, so a new code is reflected in the index on the third rising edge after it is applied.
- R3: When the mode code is 11 the select code is ignored and the index holds. With any other mode value, the synchronized selection is applied at the next rising edge.
- R4: The switch pulse is high for exactly one cycle, in the same cycle the index takes its new value. A code change that maps to the same index, such as 10 to 11, gives no pulse.
- R5: A cycle with the in-window flag low clears the qualify count, and lock is low from the next cycle on.
- R6: Lock rises on the edge where the LOCK_TICKS-th consecutive in-window tick is counted, and never earlier. An out-of-window cycle during qualification restarts the count from zero.
- R7: A reference switch while the in-window flag stays high leaves lock asserted, with no glitch.
- R8: The count saturates at LOCK_TICKS, so further in-window ticks keep lock high and the count never wraps.
- R9: In-window cycles without a qualify tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode; 11 selects automatic mode |
| sel_i | input | 2 | Manual reference select code (asynchronous) |
| in_window_i | input | 1 | Phase is inside the lock window this cycle |
| qual_tick_i | input | 1 | Lock-qualify timer tick |
| ref_idx_o | output | 2 | Active reference index (0, 1 or 2) |
| switch_pulse_o | output | 1 | One-cycle pulse when the index changes |
| lock_o | output | 1 | Qualified lock status |

## Verification
The bench builds the block with LOCK_TICKS set to 5 and the synchronizer at its default depth of two. This keeps a full qualification run short enough to repeat after an interruption at tick 3. The bench checks the boundary at every qualification run: lock is still low after the fourth tick and high after the fifth. Saturation is confirmed by ticking well past five while lock stays high.

// File: rtl/ref_lock_pkg.sv
package ref_lock_pkg;
  localparam int IDX_W = 2;
  localparam logic [1:0] MODE_AUTO = 2'b11;

  function automatic logic [IDX_W-1:0] code_to_idx(input logic [1:0] code);
    logic [IDX_W-1:0] idx;
    case (code)
      2'b00:   idx = 2'd0;
      2'b01:   idx = 2'd1;
      default: idx = 2'd2;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/ref_code_sync.sv
module ref_code_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ref_selector.sv
module ref_selector
  import ref_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       code_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             pulse_o
);
  logic [IDX_W-1:0] want;
  logic             manual;

  always_comb begin
    want   = code_to_idx(code_i);
    manual = (mode_i != MODE_AUTO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (manual && (want != idx_o)) begin
        idx_o   <= want;
        pulse_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int LOCK_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_window_i,
  input  logic tick_i,
  output logic lock_o
);
  localparam int TW = $clog2(LOCK_TICKS + 1);
  localparam logic [TW-1:0] FULL = TW'(LOCK_TICKS);
  localparam logic [TW-1:0] LAST = TW'(LOCK_TICKS - 1);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      lock_o  <= 1'b0;
    end else if (!in_window_i) begin
      count_q <= '0;
      lock_o  <= 1'b0;
    end else if (tick_i && (count_q != FULL)) begin
      count_q <= count_q + 1'b1;
      if (count_q == LAST) lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ref_lock_ctl.sv
module ref_lock_ctl
  import ref_lock_pkg::*;
#(
  parameter int LOCK_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic [1:0] sel_i,
  input  logic       in_window_i,
  input  logic       qual_tick_i,
  output logic [1:0] ref_idx_o,
  output logic       switch_pulse_o,
  output logic       lock_o
);
  logic [1:0] sel_sync;

  ref_code_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(sel_i), .sync_o(sel_sync)
  );

  ref_selector u_sel (
    .clk(clk), .rst(rst), .mode_i(mode_i), .code_i(sel_sync),
    .idx_o(ref_idx_o), .pulse_o(switch_pulse_o)
  );

  lock_qualifier #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst(rst), .in_window_i(in_window_i), .tick_i(qual_tick_i),
    .lock_o(lock_o)
  );
endmodule

// File: rtl/ref_lock_ctl_chk.sv
module ref_lock_ctl_chk #(
  parameter int LOCK_TICKS = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       in_window_i,
  input logic       qual_tick_i,
  input logic [1:0] ref_idx_o,
  input logic       switch_pulse_o,
  input logic       lock_o
);
  localparam int TW = $clog2(LOCK_TICKS + 1);
  logic [TW-1:0] run_q;

  // independent count of consecutive in-window ticks, saturating
  always_ff @(posedge clk) begin
    if (rst || !in_window_i) run_q <= '0;
    else if (qual_tick_i && (run_q != TW'(LOCK_TICKS))) run_q <= run_q + 1'b1;
  end

  p_idx_legal_r2: assert property (@(posedge clk) disable iff (rst)
    ref_idx_o != 2'd3);

  p_auto_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11) |=> $stable(ref_idx_o));

  p_pulse_on_change_r4: assert property (@(posedge clk) disable iff (rst)
    switch_pulse_o == (ref_idx_o != $past(ref_idx_o)));

  p_drop_lock_r5: assert property (@(posedge clk) disable iff (rst)
    !in_window_i |=> !lock_o);

  p_full_run_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (run_q == TW'(LOCK_TICKS)));

  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(qual_tick_i));

  p_hold_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_o && in_window_i) |=> lock_o);
endmodule

bind ref_lock_ctl ref_lock_ctl_chk #(.LOCK_TICKS(LOCK_TICKS)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .in_window_i(in_window_i),
  .qual_tick_i(qual_tick_i), .ref_idx_o(ref_idx_o),
  .switch_pulse_o(switch_pulse_o), .lock_o(lock_o)
);

// File: tb/tb_ref_lock_ctl.sv
module tb_ref_lock_ctl;
  localparam int LT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] sel = 2'b00;
  logic win = 1'b0;
  logic tick = 1'b0;
  logic [1:0] idx;
  logic pulse, lock;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ref_lock_ctl #(.LOCK_TICKS(LT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .mode_i(mode), .sel_i(sel),
    .in_window_i(win), .qual_tick_i(tick),
    .ref_idx_o(idx), .switch_pulse_o(pulse), .lock_o(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 idx", idx, 0);
    chk("R1 pulse", pulse, 0);
    chk("R1 lock", lock, 0);
  endtask

  task automatic select_and_check(input logic [1:0] code, input int exp_idx,
                                  input int old_idx);
    sel = code;
    cyc(2);
    chk("R2 not yet", idx, old_idx);
    cyc(1);
    chk("R2 idx", idx, exp_idx);
    chk("R4 pulse", pulse, 1);
    cyc(1);
    chk("R4 pulse one cycle", pulse, 0);
  endtask

  task automatic t_map();
    select_and_check(2'b01, 1, 0);
    select_and_check(2'b10, 2, 1);
    sel = 2'b11;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R4 same index no pulse", pulse, 0);
      chk("R2 11 maps to 2", idx, 2);
    end
    select_and_check(2'b00, 0, 2);
  endtask

  task automatic t_auto();
    mode = 2'b11;
    sel = 2'b01;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R3 auto ignores select", idx, 0);
      chk("R3 auto no pulse", pulse, 0);
    end
    mode = 2'b10;
    cyc(1);
    chk("R3 manual applies", idx, 1);
    chk("R4 pulse", pulse, 1);
    mode = 2'b00;
    cyc(1);
  endtask

  task automatic t_qualify();
    win = 1'b1;
    tick = 1'b0;
    cyc(20);
    chk("R9 no ticks no lock", lock, 0);
    tick = 1'b1;
    cyc(LT - 1);
    chk("R6 early", lock, 0);
    cyc(1);
    chk("R6 lock at full", lock, 1);
    cyc(12);
    chk("R8 saturate", lock, 1);
  endtask

  task automatic t_switch_hold();
    sel = 2'b10;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R7 lock held across switch", lock, 1);
    end
    chk("R7 switched", idx, 2);
  endtask

  task automatic t_lose_and_restart();
    win = 1'b0;
    cyc(1);
    chk("R5 lock drops", lock, 0);
    win = 1'b1;
    tick = 1'b1;
    cyc(3);
    win = 1'b0;
    cyc(1);
    win = 1'b1;
    cyc(LT - 1);
    chk("R6 restart not early", lock, 0);
    cyc(1);
    chk("R6 relock", lock, 1);
    tick = 1'b0;
    cyc(1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_map();
    t_auto();
    t_qualify();
    t_switch_hold();
    t_lose_and_restart();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule